// File: doc/BRIEF.md
# Serial Clock Divider With Linear And Power-of-Two Stages

This block produces the serial clock of an SPI master from the system clock. A single prescale byte selects the divide ratio. The byte is split into a four-bit linear factor and a three-bit exponent. The serial clock period is the linear factor times two to the power of the exponent, counted in system clocks. A power-of-two prescale counter drives a modulo-N phase counter, and the two counters together mark the half-period point and the end of each period.

Alongside the clock level, the block emits two one-cycle strobes that coincide with the clock transitions. The shift logic uses one strobe to launch data and the other to capture it. The clock idles low while the block is stopped. A new ratio is taken up only at a clean period boundary, so the clock never produces a runt or stretched pulse when software reprograms the byte during a transfer.

Top module: `sck_divgen`

## Requirements
- R1: The linear factor F is prescale bits 3:0. The exponent E is built from prescale bit 6 (E bit 2), bit 5 (E bit 1) and bit 4 (E bit 0). One serial clock period lasts N = F * 2^E system clocks.
- R2: Prescale bit 7 has no effect on the serial clock.
- R3: Within each period, the clock is high for ceil(N/2) cycles and then low for floor(N/2) cycles. When N is odd, the high phase is one cycle longer than the low phase.
- R4: lead_o is high for exactly the one cycle in which sck_o first reads high in a period. trail_o is high for exactly the one cycle in which sck_o first reads low after being high.
- R5: When F is 0, the clock is stopped: sck_o stays low and neither strobe fires.
- R6: A total ratio of 1 (F = 1, E = 0) is run as a ratio of 2, giving one cycle high and one cycle low.
- R7: A prescale change made during a running period does not alter that period. It takes effect from the next period.
- R8: While run_i is low, sck_o is low one cycle later. Dropping run_i while the clock is high ends the high phase and raises trail_o for that cycle.
- R9: Reset holds sck_o, lead_o and trail_o low. When run_i is sampled high with a nonzero F after a stop, sck_o and lead_o rise at the following clock edge.
- R10: lead_o and trail_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Enables clock generation |
| prescale_i | input | 8 | Packed divide-ratio byte |
| sck_o | output | 1 | Serial clock level, idle low |
| lead_o | output | 1 | One-cycle strobe on the rising clock transition |
| trail_o | output | 1 | One-cycle strobe on the falling clock transition |

## Verification
Several relations are checked on every cycle: each strobe coincides with the matching clock transition, the two strobes never overlap, the clock is forced low after run_i is low, a zero linear factor keeps the clock low, and the clock starts one edge after run_i rises. The exact phase lengths for each decoded ratio can only be shown by the bench, which counts the high and low cycles of whole periods. The same holds for the rule that a mid-period reprogramming leaves the running period intact, for ignoring bit 7, and for running ratio 1 as ratio 2.

// File: rtl/sckgen_pkg.sv
package sckgen_pkg;

    localparam int PS_W   = 8;
    localparam int SPR_W  = 4;
    localparam int SPPR_W = 3;
    localparam int PRE_W  = (1 << SPPR_W) - 1;

    typedef struct packed {
        logic [SPR_W-1:0]  lin;
        logic [SPPR_W-1:0] expo;
    } div_cfg_t;

    typedef struct packed {
        logic [SPR_W-1:0] ph;
        logic [PRE_W-1:0] pre;
    } div_pos_t;

    typedef enum logic {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } gen_state_e;

    // Split the packed byte into factor and exponent; bit 7 is not used.
    function automatic div_cfg_t unpack_prescale(input logic [PS_W-1:0] ps);
        div_cfg_t c;
        c.lin  = ps[3:0];
        c.expo = {ps[6], ps[5], ps[4]};
        if (c.lin == SPR_W'(1) && c.expo == '0) begin
            c.lin = SPR_W'(2);
        end
        return c;
    endfunction

    // Position of the falling transition: ceil(N/2) in counter coordinates.
    function automatic div_pos_t half_point(input div_cfg_t c);
        div_pos_t         h;
        logic [SPR_W:0]   inc;
        h   = '0;
        inc = {1'b0, c.lin} + (SPR_W+1)'(1);
        if (c.expo == '0) begin
            h.ph = inc[SPR_W:1];
        end else begin
            h.ph = c.lin >> 1;
            if (c.lin[0]) begin
                h.pre = PRE_W'(1) << SPPR_W'(c.expo - SPPR_W'(1));
            end
        end
        return h;
    endfunction

endpackage

// File: rtl/sckgen_precnt.sv
module sckgen_precnt
    import sckgen_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              clr_i,
    input  logic              adv_i,
    input  logic [SPPR_W-1:0] expo_i,
    output logic [PRE_W-1:0]  nxt_o,
    output logic              last_o
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] lim;

    always_comb begin
        lim    = PRE_W'((32'd1 << expo_i) - 32'd1);
        last_o = (cnt_q == lim);
        nxt_o  = last_o ? '0 : cnt_q + PRE_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            cnt_q <= '0;
        end else if (adv_i) begin
            cnt_q <= nxt_o;
        end
    end
endmodule

// File: rtl/sckgen_phcnt.sv
module sckgen_phcnt
    import sckgen_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clr_i,
    input  logic             adv_i,
    input  logic             step_i,
    input  logic [SPR_W-1:0] lin_i,
    output logic [SPR_W-1:0] nxt_o,
    output logic             last_o
);
    logic [SPR_W-1:0] cnt_q;

    always_comb begin
        last_o = (cnt_q == lin_i - SPR_W'(1));
        if (step_i) begin
            nxt_o = last_o ? '0 : cnt_q + SPR_W'(1);
        end else begin
            nxt_o = cnt_q;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            cnt_q <= '0;
        end else if (adv_i) begin
            cnt_q <= nxt_o;
        end
    end
endmodule

// File: rtl/sckgen_edges.sv
module sckgen_edges (
    input  logic clk_i,
    input  logic rst_i,
    input  logic start_i,
    input  logic stop_i,
    input  logic fall_i,
    output logic sck_o,
    output logic lead_o,
    output logic trail_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sck_o   <= 1'b0;
            lead_o  <= 1'b0;
            trail_o <= 1'b0;
        end else if (stop_i) begin
            sck_o   <= 1'b0;
            lead_o  <= 1'b0;
            trail_o <= sck_o;
        end else if (start_i) begin
            sck_o   <= 1'b1;
            lead_o  <= 1'b1;
            trail_o <= 1'b0;
        end else if (fall_i) begin
            sck_o   <= 1'b0;
            lead_o  <= 1'b0;
            trail_o <= 1'b1;
        end else begin
            lead_o  <= 1'b0;
            trail_o <= 1'b0;
        end
    end
endmodule

// File: rtl/sck_divgen.sv
module sck_divgen
    import sckgen_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            run_i,
    input  logic [PS_W-1:0] prescale_i,
    output logic            sck_o,
    output logic            lead_o,
    output logic            trail_o
);
    gen_state_e       state_q;
    div_cfg_t         cfg_q;
    div_cfg_t         dec;
    div_pos_t         hp;
    logic [PRE_W-1:0] pre_nxt;
    logic             pre_last;
    logic [SPR_W-1:0] ph_nxt;
    logic             ph_last;
    logic             boundary;
    logic             do_start;
    logic             do_stop;
    logic             do_adv;
    logic             hit;

    always_comb begin
        dec      = unpack_prescale(prescale_i);
        hp       = half_point(cfg_q);
        boundary = (state_q == ST_STOP) || (pre_last && ph_last);
        do_start = 1'b0;
        do_stop  = 1'b0;
        do_adv   = 1'b0;
        if (!run_i) begin
            do_stop = 1'b1;
        end else if (boundary) begin
            if (dec.lin != '0) begin
                do_start = 1'b1;
            end else begin
                do_stop = 1'b1;
            end
        end else begin
            do_adv = 1'b1;
        end
        hit = do_adv && (ph_nxt == hp.ph) && (pre_nxt == hp.pre);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_STOP;
            cfg_q   <= '0;
        end else begin
            if (!run_i || boundary) begin
                cfg_q <= dec;
            end
            if (do_stop) begin
                state_q <= ST_STOP;
            end else if (do_start) begin
                state_q <= ST_RUN;
            end
        end
    end

    sckgen_precnt u_pre (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (do_start || do_stop),
        .adv_i  (do_adv),
        .expo_i (cfg_q.expo),
        .nxt_o  (pre_nxt),
        .last_o (pre_last)
    );

    sckgen_phcnt u_ph (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (do_start || do_stop),
        .adv_i  (do_adv),
        .step_i (pre_last),
        .lin_i  (cfg_q.lin),
        .nxt_o  (ph_nxt),
        .last_o (ph_last)
    );

    sckgen_edges u_edge (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .start_i (do_start),
        .stop_i  (do_stop),
        .fall_i  (hit),
        .sck_o   (sck_o),
        .lead_o  (lead_o),
        .trail_o (trail_o)
    );
endmodule

// File: rtl/sckgen_checker.sv
module sckgen_checker (
    input logic       clk_i,
    input logic       rst_i,
    input logic       run_i,
    input logic [3:0] lin_field_i,
    input logic       sck_o,
    input logic       lead_o,
    input logic       trail_o
);
    p_lead_on_rise_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |-> (lead_o == $rose(sck_o)));

    p_trail_on_fall_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |-> (trail_o == $fell(sck_o)));

    p_strobes_apart_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        !(lead_o && trail_o));

    p_idle_low_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_i |=> !sck_o);

    p_zero_factor_hold_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!sck_o && lin_field_i == 4'd0) |=> !sck_o);

    p_start_latency_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_i ##1 (run_i && lin_field_i != 4'd0) |=> (sck_o && lead_o));
endmodule

bind sck_divgen sckgen_checker u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .run_i       (run_i),
    .lin_field_i (prescale_i[3:0]),
    .sck_o       (sck_o),
    .lead_o      (lead_o),
    .trail_o     (trail_o)
);

// File: tb/sim_sck_divgen.sv
`timescale 1ns/1ps
module sim_sck_divgen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic [7:0] ps  = 8'h00;
    logic       sck, lead, trail;

    int n_chk  = 0;
    int n_fail = 0;
    int n_both = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sck_divgen u0 (
        .clk_i      (clk),
        .rst_i      (rst),
        .run_i      (run),
        .prescale_i (ps),
        .sck_o      (sck),
        .lead_o     (lead),
        .trail_o    (trail)
    );

    // byte, expected high cycles, expected low cycles
    localparam int NV = 9;
    localparam logic [7:0] V_PS [NV] = '{8'h02, 8'h03, 8'h0F, 8'h12, 8'h25,
                                         8'h45, 8'h7F, 8'h51, 8'h0A};
    localparam int V_HI [NV] = '{1, 2, 8, 2, 10, 40, 960, 16, 5};
    localparam int V_LO [NV] = '{1, 1, 7, 2, 10, 40, 960, 16, 5};

    always @(negedge clk) begin
        if (!rst && lead && trail) n_both++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Current sample must be the first high cycle; returns at the next one.
    task automatic measure(output int hi, output int lo, output bit tr_ok, output bit ld_ok);
        hi = 0;
        lo = 0;
        while (sck && hi < 5000) begin
            hi++;
            @(negedge clk);
        end
        tr_ok = trail;
        while (!sck && lo < 5000) begin
            lo++;
            @(negedge clk);
        end
        ld_ok = lead;
    endtask

    task automatic launch(input logic [7:0] v);
        run = 1'b0;
        ps  = v;
        repeat (2) @(negedge clk);
        run = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int hi, lo, cnt;
        bit tr, ld;
        repeat (3) @(negedge clk);
        chk(!sck && !lead && !trail, "R9 outputs low in reset", {sck, lead, trail}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!sck && !lead && !trail, "R9 outputs low after reset", {sck, lead, trail}, 0);

        for (int i = 0; i < NV; i++) begin
            launch(V_PS[i]);
            chk(sck && lead, "R9 clock starts one edge after run", {sck, lead}, 3);
            measure(hi, lo, tr, ld);
            chk(hi == V_HI[i], "R1 R3 high phase length", hi, V_HI[i]);
            chk(lo == V_LO[i], "R1 R3 low phase length", lo, V_LO[i]);
            chk(tr && ld, "R4 strobes at transitions", {tr, ld}, 3);
        end

        // R6: ratio one is run as ratio two
        launch(8'h01);
        measure(hi, lo, tr, ld);
        chk(hi == 1 && lo == 1, "R6 ratio one high", hi, 1);
        chk(lo == 1, "R6 ratio one low", lo, 1);

        // R2: bit 7 set versus clear gives the same 12/12 period
        launch(8'hB3);
        measure(hi, lo, tr, ld);
        chk(hi == 12, "R2 bit7 set high", hi, 12);
        chk(lo == 12, "R2 bit7 set low", lo, 12);
        launch(8'h33);
        measure(hi, lo, tr, ld);
        chk(hi == 12 && lo == 12, "R2 bit7 clear period", hi + lo, 24);

        // R5: zero factor keeps the clock stopped
        launch(8'h70);
        cnt = 0;
        for (int k = 0; k < 40; k++) begin
            if (sck || lead || trail) cnt++;
            @(negedge clk);
        end
        chk(cnt == 0, "R5 zero factor stays idle", cnt, 0);
        launch(8'h02);
        ps = 8'h00;
        repeat (4) @(negedge clk);
        cnt = 0;
        for (int k = 0; k < 20; k++) begin
            if (sck || lead || trail) cnt++;
            @(negedge clk);
        end
        chk(cnt == 0, "R5 zero factor stops running clock", cnt, 0);

        // R7: change during the first period takes effect next period
        launch(8'h05);
        ps = 8'h0F;
        measure(hi, lo, tr, ld);
        chk(hi == 3, "R7 current period high kept", hi, 3);
        chk(lo == 2, "R7 current period low kept", lo, 2);
        measure(hi, lo, tr, ld);
        chk(hi == 8 && lo == 7, "R7 new ratio next period", hi * 100 + lo, 807);

        // R8: dropping run during the high phase
        launch(8'h0F);
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        chk(!sck, "R8 clock low after run drop", sck, 0);
        chk(trail, "R8 trail strobe on run drop", trail, 1);
        @(negedge clk);
        chk(!trail && !sck, "R8 strobe single cycle", {trail, sck}, 0);

        chk(n_both == 0, "R10 strobes never overlap", n_both, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule